// File: doc/BRIEF.md
# Vector Length Setting Unit

This unit carries out the instruction that configures vector length. It takes a 32-bit instruction word together with the current value of the register named in the RA field and the value of the loop count register (CTR). It holds three pieces of architectural state: the maximum vector length (MVL), the active vector length (VL) and a vertical-first mode flag. Each valid instruction finishes in one cycle.

The instruction carries a 7-bit, one-based immediate and three flag bits. One flag enables the MVL write, one enables the VL write and one sets vertical-first mode. When VL is written, its requested length comes from the immediate, from the RA register value, or from CTR. CTR is chosen through a particular combination of the vertical-first bit and the register fields. The requested length is always limited to the MVL that results from the same instruction.

The new VL is also offered for writeback to register RT whenever RT is not register 0. All results, including the done strobe and the writeback, appear together in the cycle after the instruction is presented.

Top module: `vl_set_unit`

## Requirements
- R1: After reset, MVL and VL both read 1, the vertical-first flag reads 0, and done and the writeback enable are both low.
- R2: Bits are numbered from the most significant end, so bit 0 of the word is insn[31]. The immediate is word bits 16..22 (insn[15:9]), the MVL-write flag is bit 23 (insn[8]), the VL-write flag is bit 24 (insn[7]) and the vertical-first bit is bit 25 (insn[6]). RT is bits 6..10 (insn[25:21]) and RA is bits 11..15 (insn[20:16]). All other bits are ignored.
- R3: With the MVL-write flag set, MVL becomes the immediate plus one, so 0 gives 1 and 127 gives 128. With the flag clear, MVL is unchanged.
- R4: With the VL-write flag set, RA equal to 0 and CTR not selected, VL becomes min(immediate + 1, MVL).
- R5: With the VL-write flag set and RA not 0, VL becomes min(RA value, MVL). An RA value of 0 gives VL = 0.
- R6: With the VL-write flag set, the vertical-first bit 1, RA equal to 0 and RT not 0, VL becomes min(CTR, MVL).
- R7: The MVL used for limiting VL is the value after this instruction's MVL write. When both flags are set and the immediate is the source, MVL and VL end up equal.
- R8: With the VL-write flag clear, VL becomes min(old VL, new MVL).
- R9: Every valid instruction loads the vertical-first flag from its bit 25.
- R10: In the cycle after a valid instruction with RT not 0, the writeback enable is high for one cycle and the writeback data equals the new VL, zero-extended. When RT is 0 the enable stays low.
- R11: Done is high exactly in the cycle after each valid instruction. Without a valid instruction, MVL, VL and the flag keep their values.
- R12: VL never exceeds MVL, and MVL is never 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn | input | 32 | Instruction word |
| ra_val | input | XLEN | Value of the register selected by RA |
| ctr_val | input | XLEN | Value of the loop count register |
| mvl | output | 8 | Maximum vector length |
| vl | output | 8 | Active vector length |
| vfirst | output | 1 | Vertical-first mode flag |
| rt_wen | output | 1 | Writeback enable for RT |
| rt_wdata | output | XLEN | Writeback value for RT (new VL) |
| done | output | 1 | Instruction completed |

## Verification
The assertions assume that ra_val and ctr_val are stable and meaningful in any cycle where insn_valid is high. They also assume that the bits outside the decoded fields may carry any value. The stimulus varies the ignored opcode bits freely and biases the RA and RT indices toward 0 so that every length source is exercised. It mixes small and 64-bit-wide RA and CTR values, so that both sides of the limit against MVL occur, and inserts idle cycles between instructions.

// File: rtl/vsu_pkg.sv
package vsu_pkg;
  localparam int unsigned INSN_W    = 32;
  localparam int unsigned IMM_W     = 7;
  localparam int unsigned LEN_W     = IMM_W + 1;
  localparam int unsigned REG_IDX_W = 5;

  // field positions given MSB-first, converted to LSB indices
  localparam int unsigned IMM_POS   = 16;
  localparam int unsigned MS_POS    = 23;
  localparam int unsigned VS_POS    = 24;
  localparam int unsigned VF_POS    = 25;
  localparam int unsigned RT_POS    = 6;
  localparam int unsigned RA_POS    = 11;

  localparam int unsigned IMM_LSB   = INSN_W - (IMM_POS + IMM_W);
  localparam int unsigned MS_BIT    = INSN_W - 1 - MS_POS;
  localparam int unsigned VS_BIT    = INSN_W - 1 - VS_POS;
  localparam int unsigned VF_BIT    = INSN_W - 1 - VF_POS;
  localparam int unsigned RT_LSB    = INSN_W - (RT_POS + REG_IDX_W);
  localparam int unsigned RA_LSB    = INSN_W - (RA_POS + REG_IDX_W);

  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_IMM  = 2'd1,
    SRC_RA   = 2'd2,
    SRC_CTR  = 2'd3
  } vl_src_e;

  typedef struct packed {
    logic [LEN_W-1:0] imm_len;
    logic             ms_en;
    logic             vf_bit;
    logic             rt_nz;
    vl_src_e          src;
  } vsu_dec_t;
endpackage

// File: rtl/vsu_rst_sync.sv
module vsu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/vsu_decode.sv
module vsu_decode
  import vsu_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output vsu_dec_t          dec
);
  logic [IMM_W-1:0]     imm_f;
  logic [REG_IDX_W-1:0] rt_f;
  logic [REG_IDX_W-1:0] ra_f;
  logic                 vs_f;
  logic                 vf_f;
  logic                 ctr_pick;
  logic                 unused_opc;

  assign imm_f = insn[IMM_LSB +: IMM_W];
  assign rt_f  = insn[RT_LSB +: REG_IDX_W];
  assign ra_f  = insn[RA_LSB +: REG_IDX_W];
  assign vs_f  = insn[VS_BIT];
  assign vf_f  = insn[VF_BIT];

  // opcode and extended-opcode bits are decoded elsewhere
  assign unused_opc = ^{insn[INSN_W-1:RT_LSB+REG_IDX_W], insn[VF_BIT-1:0]};

  // overloaded combination: vertical-first, RA is r0, RT is not r0
  assign ctr_pick = vf_f && (ra_f == '0) && (rt_f != '0);

  always_comb begin
    dec.imm_len = LEN_W'(imm_f) + LEN_W'(1);
    dec.ms_en   = insn[MS_BIT];
    dec.vf_bit  = vf_f;
    dec.rt_nz   = (rt_f != '0);
    if (!vs_f) begin
      dec.src = SRC_HOLD;
    end else if (ctr_pick) begin
      dec.src = SRC_CTR;
    end else if (ra_f != '0) begin
      dec.src = SRC_RA;
    end else begin
      dec.src = SRC_IMM;
    end
  end
endmodule

// File: rtl/vsu_clamp.sv
module vsu_clamp #(
  parameter int unsigned REQ_W = 64,
  parameter int unsigned LIM_W = 8
) (
  input  logic [REQ_W-1:0] req,
  input  logic [LIM_W-1:0] limit,
  output logic [LIM_W-1:0] len
);
  logic over;

  assign over = (req > REQ_W'(limit));
  assign len  = over ? limit : req[LIM_W-1:0];
endmodule

// File: rtl/vsu_len_sel.sv
module vsu_len_sel
  import vsu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  vsu_dec_t         dec,
  input  logic [XLEN-1:0]  ra_val,
  input  logic [XLEN-1:0]  ctr_val,
  input  logic [LEN_W-1:0] cur_mvl,
  input  logic [LEN_W-1:0] cur_vl,
  output logic [LEN_W-1:0] mvl_nxt,
  output logic [LEN_W-1:0] vl_nxt
);
  logic [XLEN-1:0] req;

  // new MVL first, so VL is limited against it
  assign mvl_nxt = dec.ms_en ? dec.imm_len : cur_mvl;

  always_comb begin
    unique case (dec.src)
      SRC_CTR:  req = ctr_val;
      SRC_RA:   req = ra_val;
      SRC_IMM:  req = XLEN'(dec.imm_len);
      default:  req = XLEN'(cur_vl);
    endcase
  end

  vsu_clamp #(
    .REQ_W (XLEN),
    .LIM_W (LEN_W)
  ) u_clamp (
    .req   (req),
    .limit (mvl_nxt),
    .len   (vl_nxt)
  );
endmodule

// File: rtl/vl_set_unit.sv
module vl_set_unit
  import vsu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic [INSN_W-1:0] insn,
  input  logic [XLEN-1:0]   ra_val,
  input  logic [XLEN-1:0]   ctr_val,
  output logic [LEN_W-1:0]  mvl,
  output logic [LEN_W-1:0]  vl,
  output logic              vfirst,
  output logic              rt_wen,
  output logic [XLEN-1:0]   rt_wdata,
  output logic              done
);
  logic             rst_q_n;
  vsu_dec_t         dec;
  logic [LEN_W-1:0] mvl_q, mvl_d, mvl_calc;
  logic [LEN_W-1:0] vl_q, vl_d, vl_calc;
  logic             vf_q, vf_d;
  logic             wen_q, wen_d;
  logic [XLEN-1:0]  wdata_q, wdata_d;
  logic             done_q, done_d;
  logic             st_en;

  vsu_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  vsu_decode u_dec (
    .insn (insn),
    .dec  (dec)
  );

  vsu_len_sel #(.XLEN(XLEN)) u_sel (
    .dec     (dec),
    .ra_val  (ra_val),
    .ctr_val (ctr_val),
    .cur_mvl (mvl_q),
    .cur_vl  (vl_q),
    .mvl_nxt (mvl_calc),
    .vl_nxt  (vl_calc)
  );

  assign st_en = insn_valid;

  always_comb begin
    mvl_d   = mvl_calc;
    vl_d    = vl_calc;
    vf_d    = dec.vf_bit;
    wdata_d = XLEN'(vl_calc);
    wen_d   = insn_valid && dec.rt_nz;
    done_d  = insn_valid;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mvl_q   <= LEN_W'(1);
      vl_q    <= LEN_W'(1);
      vf_q    <= 1'b0;
      wdata_q <= '0;
    end else if (st_en) begin
      mvl_q   <= mvl_d;
      vl_q    <= vl_d;
      vf_q    <= vf_d;
      wdata_q <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      wen_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      wen_q  <= wen_d;
      done_q <= done_d;
    end
  end

  assign mvl      = mvl_q;
  assign vl       = vl_q;
  assign vfirst   = vf_q;
  assign rt_wen   = wen_q;
  assign rt_wdata = wdata_q;
  assign done     = done_q;
endmodule

// File: rtl/vsu_checker.sv
module vsu_checker
  import vsu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              insn_valid,
  input logic [INSN_W-1:0] insn,
  input logic [LEN_W-1:0]  mvl,
  input logic [LEN_W-1:0]  vl,
  input logic              vfirst,
  input logic              rt_wen,
  input logic [XLEN-1:0]   rt_wdata,
  input logic              done
);
  logic ra_zero, rt_zero, ctr_case;
  assign ra_zero  = (insn[RA_LSB +: REG_IDX_W] == '0);
  assign rt_zero  = (insn[RT_LSB +: REG_IDX_W] == '0);
  assign ctr_case = insn[VF_BIT] && ra_zero && !rt_zero;

  assert_vl_le_mvl_R12: assert property (@(posedge clk) disable iff (!rst_q_n)
    (vl <= mvl) && (mvl != '0));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    !insn_valid |=> $stable(mvl) && $stable(vl) && $stable(vfirst) && !done && !rt_wen);

  assert_done_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    insn_valid |=> done);

  assert_mvl_load_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    insn_valid && insn[MS_BIT] |=>
      mvl == LEN_W'($past(insn[IMM_LSB +: IMM_W])) + LEN_W'(1));

  assert_mvl_keep_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    insn_valid && !insn[MS_BIT] |=> $stable(mvl));

  assert_vf_load_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    insn_valid |=> vfirst == $past(insn[VF_BIT]));

  assert_wb_en_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    insn_valid |=> rt_wen == !$past(rt_zero));

  assert_wb_data_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    rt_wen |-> rt_wdata == XLEN'(vl));

  assert_both_equal_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    insn_valid && insn[MS_BIT] && insn[VS_BIT] && ra_zero && !ctr_case |=> vl == mvl);
endmodule

bind vl_set_unit vsu_checker #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .insn_valid (insn_valid),
  .insn       (insn),
  .mvl        (mvl),
  .vl         (vl),
  .vfirst     (vfirst),
  .rt_wen     (rt_wen),
  .rt_wdata   (rt_wdata),
  .done       (done)
);

// File: tb/sim_vl_set_unit.sv
module sim_vl_set_unit;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN       = 64;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             insn_valid;
  logic [31:0]      insn;
  logic [XLEN-1:0]  ra_val, ctr_val;
  logic [7:0]       mvl, vl;
  logic             vfirst, rt_wen, done;
  logic [XLEN-1:0]  rt_wdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] m_mvl, m_vl;
  logic       m_vf;

  always #(CLK_PERIOD/2) clk = ~clk;

  vl_set_unit #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .ra_val(ra_val), .ctr_val(ctr_val), .mvl(mvl), .vl(vl), .vfirst(vfirst),
    .rt_wen(rt_wen), .rt_wdata(rt_wdata), .done(done)
  );

  function automatic logic [31:0] mk(input logic [6:0] imm, input logic ms,
      input logic vs, input logic vf, input logic [4:0] rt, input logic [4:0] ra);
    logic [31:0] w = 32'd0;
    w[15:9] = imm; w[8] = ms; w[7] = vs; w[6] = vf;
    w[25:21] = rt; w[20:16] = ra;
    return w;
  endfunction

  function automatic logic [7:0] clampv(input logic [63:0] req, input logic [7:0] lim);
    return (req > {56'd0, lim}) ? lim : req[7:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
      input logic [63:0] exp, input string note);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s): actual %0d expected %0d", tag, note, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] w, input logic [63:0] ra, input logic [63:0] ctr,
      input logic v, input string note);
    logic [7:0] imm_len, mvl_n, vl_n;
    logic [4:0] rt_i, ra_i;
    string vtag;
    logic exp_wen;
    rt_i = w[25:21]; ra_i = w[20:16];
    imm_len = {1'b0, w[15:9]} + 8'd1;
    mvl_n = (v && w[8]) ? imm_len : m_mvl;
    if (!v) begin vl_n = m_vl; vtag = "R11"; end
    else if (!w[7]) begin vl_n = clampv({56'd0, m_vl}, mvl_n); vtag = "R8"; end
    else if (w[6] && ra_i == 0 && rt_i != 0) begin vl_n = clampv(ctr, mvl_n); vtag = "R6"; end
    else if (ra_i != 0) begin vl_n = clampv(ra, mvl_n); vtag = "R5"; end
    else begin vl_n = clampv({56'd0, imm_len}, mvl_n); vtag = "R4"; end
    exp_wen = v && (rt_i != 0);
    insn = w; ra_val = ra; ctr_val = ctr; insn_valid = v;
    @(negedge clk);
    insn_valid = 1'b0;
    chk(mvl == mvl_n, v ? "R3" : "R11", mvl, mvl_n, note);
    chk(vl == vl_n, vtag, vl, vl_n, note);
    chk(vfirst == (v ? w[6] : m_vf), "R9", vfirst, v ? w[6] : m_vf, note);
    chk(done == v, "R11", done, v, note);
    chk(rt_wen == exp_wen, "R10", rt_wen, exp_wen, note);
    if (exp_wen) chk(rt_wdata == {56'd0, vl_n}, "R10", rt_wdata, {56'd0, vl_n}, note);
    chk(vl <= mvl && mvl != 0, "R12", vl, mvl, note);
    m_mvl = mvl_n; m_vl = vl_n;
    if (v) m_vf = w[6];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [63:0] ra, ctr;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; insn_valid = 1'b0; insn = '0; ra_val = '0; ctr_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(mvl == 8'd1, "R1", mvl, 1, "reset mvl");
    chk(vl == 8'd1, "R1", vl, 1, "reset vl");
    chk(vfirst == 1'b0 && done == 1'b0 && rt_wen == 1'b0, "R1",
        {vfirst, done, rt_wen}, 0, "reset flags");
    m_mvl = 8'd1; m_vl = 8'd1; m_vf = 1'b0;

    // R3 R7 immediate extremes, both flags set
    step(mk(7'd127, 1, 1, 0, 5'd3, 0), 0, 0, 1, "R7 imm 127 both");
    chk(mvl == 8'd128 && vl == 8'd128, "R7", vl, 128, "both equal 128");
    step(mk(7'd0, 1, 1, 0, 0, 0), 0, 0, 1, "R3 imm 0 gives 1");
    step(mk(7'd63, 1, 0, 0, 0, 0), 0, 0, 1, "R3 mvl only");
    step(mk(7'd99, 0, 1, 0, 5'd1, 0), 0, 0, 1, "R4 imm above mvl");
    step(mk(7'd9, 1, 0, 0, 0, 0), 0, 0, 1, "R8 mvl shrinks below vl");
    // R5 RA source
    step(mk(7'd127, 1, 0, 0, 0, 0), 0, 0, 1, "R3 mvl 128");
    step(mk(7'd5, 0, 1, 0, 5'd7, 5'd4), 64'hFFFF_0000_0000_0000, 0, 1, "R5 huge RA");
    step(mk(7'd5, 0, 1, 0, 5'd7, 5'd4), 64'd17, 0, 1, "R5 RA 17");
    step(mk(7'd5, 0, 1, 0, 0, 5'd4), 64'd0, 0, 1, "R5 RA zero");
    // R6 CTR source, and its near misses
    step(mk(7'd3, 0, 1, 1, 5'd2, 0), 0, 64'd40, 1, "R6 ctr 40");
    step(mk(7'd3, 0, 1, 1, 5'd2, 0), 0, 64'd1000, 1, "R6 ctr clamped");
    step(mk(7'd3, 0, 1, 1, 0, 0), 0, 64'd50, 1, "R4 vf with rt zero");
    step(mk(7'd3, 1, 1, 1, 5'd2, 0), 0, 64'd50, 1, "R7 ctr against new mvl");
    // R2 ignored bits set all over
    w = mk(7'd20, 1, 1, 0, 5'd9, 0) | 32'hFC00_003F;
    step(w, 0, 0, 1, "R2 noise bits");
    step(w, 64'd5, 64'd5, 0, "R11 idle");

    for (int i = 0; i < 600; i++) begin
      logic [4:0] rt_r, ra_r;
      rt_r = ($urandom % 3 == 0) ? 5'd0 : 5'($urandom);
      ra_r = ($urandom % 2 == 0) ? 5'd0 : 5'($urandom);
      w = mk(7'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), rt_r, ra_r);
      w[31:26] = 6'($urandom); w[5:0] = 6'($urandom);
      ra  = ($urandom % 2 == 0) ? 64'($urandom % 200) : {$urandom, $urandom};
      ctr = ($urandom % 2 == 0) ? 64'($urandom % 200) : {$urandom, $urandom};
      step(w, ra, ctr, ($urandom % 4) != 0, "random");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule